// File: doc/BRIEF.md
# Product-Term Safety Guard Checker

This block decides whether a candidate vector of controller outputs is safe. The safety rules are held in a small table of product terms. Each term is written over one joint vector: the candidate outputs for the current scan, followed by a set of read-only variables such as sensors, observers and earlier outputs. A term that evaluates true marks a forbidden combination. The candidate is safe only when no enabled term is true.

Each table row stores a care mask and a value mask over the joint vector. Terms whose care mask covers at most one output position form the single-output group. Terms that cover two or more output positions form the multi-output group. For every candidate the block reports four things: the vector of terms that fired, a global unsafe flag, a flag over the multi-output group alone, and a per-output mark for each output named in a firing multi-output term. A search engine that proposes new candidates can use the per-output mark to restrict its flips to those outputs. All results are registered, and a valid bit travels alongside them.

Top module: `guard_term_checker`

## Requirements
- R1: While reset is held, and on the first cycle after it, `res_vld`, `unsafe`, `multi_unsafe`, `viol` and `involved` are all zero, and every table row has an all-zero care mask.
- R2: When `cfg_we` is high at a clock edge, row `cfg_idx` takes `cfg_care` and `cfg_val`. The next evaluation uses the new row and the other rows are unchanged.
- R3: The joint vector places `cand_out[k]` at bit k and `ro_in[r]` at bit N_OUT+r. Row i fires (`viol[i]`=1) when its care mask is nonzero and, at every bit set in the care mask, the joint vector equals the value mask. This covers both the true form (value 1) and the inverted form (value 0) of an output.
- R4: A bit whose care bit is 0 has no effect on whether a row fires, whatever its value-mask bit or its input bit.
- R5: A row whose care mask is all zero never fires, whatever its value mask.
- R6: `unsafe` is 1 exactly when at least one bit of `viol` is 1 for the same evaluation.
- R7: A row belongs to the multi-output group when its care mask has two or more bits set among positions 0..N_OUT-1. `multi_unsafe` is 1 exactly when a row of that group fires. A single-output row that fires leaves it at 0.
- R8: `involved[k]` is 1 exactly when output k lies in the care mask of some firing multi-output row. It is never set by single-output rows alone.
- R9: The results for the inputs sampled at a clock edge appear at the outputs just after that edge. `res_vld` is 1 there exactly when `in_vld` was 1 at that edge.
- R10: A table write and an evaluation at the same edge are ordered: the evaluation uses the table contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table row write strobe |
| cfg_idx | input | clog2(N_ROWS) | Row to write |
| cfg_care | input | N_OUT+N_RO | Care mask for the row |
| cfg_val | input | N_OUT+N_RO | Value mask for the row |
| in_vld | input | 1 | Marks the candidate on this edge as a request |
| cand_out | input | N_OUT | Candidate output vector |
| ro_in | input | N_RO | Read-only variables |
| res_vld | output | 1 | Results below belong to a request |
| unsafe | output | 1 | Some enabled row fired |
| multi_unsafe | output | 1 | Some multi-output row fired |
| viol | output | N_ROWS | Per-row fire flags |
| involved | output | N_OUT | Outputs named by firing multi-output rows |

## Verification
On every cycle the assertions check how the result signals relate to one another. The global flag must agree with the row vector. A multi-output flag implies the global flag. Any per-output mark implies the multi-output flag and comes with at least two marks. A row only fires if it was enabled, and the valid bit follows the request one cycle later. Only the bench's scenarios can show that rows match the right bit positions and polarities, and that don't-care bits are truly ignored. They are also needed to show that rows are sorted into the right group, and that writes at the same edge as an evaluation take effect in the right order.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  // Index width for a table of n rows, never below one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/gtc_table.sv
module gtc_table #(
  parameter int VW     = 10,
  parameter int N_ROWS = 8,
  parameter int IW     = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [IW-1:0]                idx,
  input  logic [VW-1:0]                care_in,
  input  logic [VW-1:0]                val_in,
  output logic [N_ROWS-1:0][VW-1:0]    care_q,
  output logic [N_ROWS-1:0][VW-1:0]    val_q
);
  logic idx_ok;
  assign idx_ok = (int'(idx) < N_ROWS);

  // All rows are read in parallel every cycle, so the table stays in flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      care_q <= '0;
      val_q  <= '0;
    end else if (we && idx_ok) begin
      care_q[idx] <= care_in;
      val_q[idx]  <= val_in;
    end
  end
endmodule

// File: rtl/gtc_term.sv
module gtc_term #(
  parameter int N_OUT = 6,
  parameter int VW    = 10
) (
  input  logic [VW-1:0]    vec,
  input  logic [VW-1:0]    care,
  input  logic [VW-1:0]    val,
  output logic             hit,
  output logic             multi,
  output logic [N_OUT-1:0] out_sel
);
  logic [VW-1:0] mismatch;

  always_comb begin
    out_sel  = care[N_OUT-1:0];
    multi    = ($countones(out_sel) > 1);
    mismatch = (vec ^ val) & care;
    hit      = (|care) && (mismatch == '0);
  end
endmodule

// File: rtl/gtc_merge.sv
module gtc_merge #(
  parameter int N_ROWS = 8,
  parameter int N_OUT  = 6
) (
  input  logic [N_ROWS-1:0]             hit,
  input  logic [N_ROWS-1:0]             multi,
  input  logic [N_ROWS-1:0][N_OUT-1:0]  out_sel,
  output logic                          any_hit,
  output logic                          any_multi,
  output logic [N_OUT-1:0]              involved
);
  always_comb begin
    any_hit   = |hit;
    any_multi = |(hit & multi);
    involved  = '0;
    for (int r = 0; r < N_ROWS; r++) begin
      if (hit[r] && multi[r]) involved = involved | out_sel[r];
    end
  end
endmodule

// File: rtl/guard_term_checker.sv
module guard_term_checker #(
  parameter int N_OUT  = 6,
  parameter int N_RO   = 4,
  parameter int N_ROWS = 8
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    cfg_we,
  input  logic [gtc_pkg::idx_width(N_ROWS)-1:0]   cfg_idx,
  input  logic [N_OUT+N_RO-1:0]                   cfg_care,
  input  logic [N_OUT+N_RO-1:0]                   cfg_val,
  input  logic                                    in_vld,
  input  logic [N_OUT-1:0]                        cand_out,
  input  logic [N_RO-1:0]                         ro_in,
  output logic                                    res_vld,
  output logic                                    unsafe,
  output logic                                    multi_unsafe,
  output logic [N_ROWS-1:0]                       viol,
  output logic [N_OUT-1:0]                        involved
);
  localparam int VW = N_OUT + N_RO;
  localparam int IW = gtc_pkg::idx_width(N_ROWS);

  logic [N_ROWS-1:0][VW-1:0]    care_q;
  logic [N_ROWS-1:0][VW-1:0]    val_q;
  logic [N_ROWS-1:0]            hit_c;
  logic [N_ROWS-1:0]            multi_c;
  logic [N_ROWS-1:0][N_OUT-1:0] sel_c;
  logic [VW-1:0]                vec;
  logic                         any_hit_c;
  logic                         any_multi_c;
  logic [N_OUT-1:0]             involved_c;

  assign vec = {ro_in, cand_out};

  gtc_table #(.VW(VW), .N_ROWS(N_ROWS), .IW(IW)) u_table (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .idx     (cfg_idx),
    .care_in (cfg_care),
    .val_in  (cfg_val),
    .care_q  (care_q),
    .val_q   (val_q)
  );

  for (genvar g = 0; g < N_ROWS; g++) begin : g_row
    gtc_term #(.N_OUT(N_OUT), .VW(VW)) u_term (
      .vec     (vec),
      .care    (care_q[g]),
      .val     (val_q[g]),
      .hit     (hit_c[g]),
      .multi   (multi_c[g]),
      .out_sel (sel_c[g])
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
      viol[g] |-> ($past(care_q[g]) != '0)); // R5
  end

  gtc_merge #(.N_ROWS(N_ROWS), .N_OUT(N_OUT)) u_merge (
    .hit       (hit_c),
    .multi     (multi_c),
    .out_sel   (sel_c),
    .any_hit   (any_hit_c),
    .any_multi (any_multi_c),
    .involved  (involved_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld      <= 1'b0;
      unsafe       <= 1'b0;
      multi_unsafe <= 1'b0;
      viol         <= '0;
      involved     <= '0;
    end else begin
      res_vld      <= in_vld;
      unsafe       <= any_hit_c;
      multi_unsafe <= any_multi_c;
      viol         <= hit_c;
      involved     <= involved_c;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld); // R9
  AST_UNSAFE_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
    unsafe |-> (|viol)); // R6
  AST_ROW_SETS_UNSAFE: assert property (@(posedge clk) disable iff (rst)
    (|viol) |-> unsafe); // R6
  AST_MULTI_IN_UNSAFE: assert property (@(posedge clk) disable iff (rst)
    multi_unsafe |-> unsafe); // R7
  AST_MARK_NEEDS_MULTI: assert property (@(posedge clk) disable iff (rst)
    (|involved) |-> multi_unsafe); // R8
  AST_MULTI_TWO_MARKS: assert property (@(posedge clk) disable iff (rst)
    multi_unsafe |-> ($countones(involved) >= 2)); // R8
endmodule

// File: tb/guard_term_checker_test.sv
`timescale 1ns/100ps
module guard_term_checker_test;
  localparam int NO = 6;
  localparam int NRO = 4;
  localparam int NR = 8;
  localparam int VW = NO + NRO;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [VW-1:0] cfg_care = '0;
  logic [VW-1:0] cfg_val = '0;
  logic in_vld = 1'b0;
  logic [NO-1:0] cand_out = '0;
  logic [NRO-1:0] ro_in = '0;
  logic res_vld, unsafe, multi_unsafe;
  logic [NR-1:0] viol;
  logic [NO-1:0] involved;

  always #2.5 clk = ~clk;

  guard_term_checker #(.N_OUT(NO), .N_RO(NRO), .N_ROWS(NR)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_care(cfg_care), .cfg_val(cfg_val), .in_vld(in_vld),
    .cand_out(cand_out), .ro_in(ro_in), .res_vld(res_vld),
    .unsafe(unsafe), .multi_unsafe(multi_unsafe), .viol(viol),
    .involved(involved)
  );

  typedef struct {
    logic [NR-1:0] viol;
    logic          uns;
    logic          mul;
    logic [NO-1:0] inv;
    string         tag;
  } exp_t;

  exp_t q[$];
  logic [VW-1:0] m_care [NR];
  logic [VW-1:0] m_val  [NR];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s) actual=%0h expected=%0h", req, tag, act, exp);
    end
  endtask

  // Reference built from the requirement text.
  function automatic exp_t model(input logic [NO-1:0] c, input logic [NRO-1:0] r, input string tag);
    exp_t e;
    logic [VW-1:0] v;
    v = {r, c};
    e.viol = '0; e.inv = '0; e.tag = tag;
    for (int i = 0; i < NR; i++) begin
      bit fire;
      int outs;
      fire = (m_care[i] != '0);
      outs = 0;
      for (int b = 0; b < VW; b++)
        if (m_care[i][b] && (v[b] != m_val[i][b])) fire = 1'b0;
      for (int b = 0; b < NO; b++) if (m_care[i][b]) outs++;
      e.viol[i] = fire;
      if (fire && outs >= 2) e.inv = e.inv | m_care[i][NO-1:0];
    end
    e.uns = |e.viol;
    e.mul = (e.inv != '0);
    return e;
  endfunction

  task automatic wr(input int idx, input logic [VW-1:0] c, input logic [VW-1:0] v);
    @(negedge clk);
    in_vld = 1'b0; cfg_we = 1'b1;
    cfg_idx = IW'(idx); cfg_care = c; cfg_val = v;
    m_care[idx] = c; m_val[idx] = v;
  endtask

  task automatic apply(input logic [NO-1:0] c, input logic [NRO-1:0] r, input string tag);
    @(negedge clk);
    cfg_we = 1'b0; in_vld = 1'b1; cand_out = c; ro_in = r;
    q.push_back(model(c, r, tag));
  endtask

  // Evaluation and write at one edge: expectation uses the old table (R10).
  task automatic apply_wr(input logic [NO-1:0] c, input logic [NRO-1:0] r,
                          input int idx, input logic [VW-1:0] cm, input logic [VW-1:0] vm);
    @(negedge clk);
    in_vld = 1'b1; cand_out = c; ro_in = r;
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_care = cm; cfg_val = vm;
    q.push_back(model(c, r, "R10 same-edge"));
    m_care[idx] = cm; m_val[idx] = vm;
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 1'b0; in_vld = 1'b0;
  endtask

  // Scoreboard monitor, sampling just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (!rst && res_vld) begin
      if (q.size() == 0) begin
        chk("R9", "result without request", 32'(res_vld), 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R3", e.tag, 32'(viol), 32'(e.viol));
        chk("R6", e.tag, 32'(unsafe), 32'(e.uns));
        chk("R7", e.tag, 32'(multi_unsafe), 32'(e.mul));
        chk("R8", e.tag, 32'(involved), 32'(e.inv));
      end
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_care[i] = '0; m_val[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "in reset", {res_vld, unsafe, multi_unsafe, viol, involved}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "after reset", {res_vld, unsafe, multi_unsafe, viol, involved}, 32'd0);

    // Empty table: every row disabled.
    apply(6'h3F, 4'hF, "R5 empty table");
    apply(6'h00, 4'h0, "R5 empty table");

    wr(0, 10'h041, 10'h041);        // out0 & ro0
    wr(1, 10'h082, 10'h080);        // !out1 & ro1
    wr(2, 10'h00C, 10'h00C);        // out2 & out3
    wr(3, 10'h138, 10'h118);        // out3 & out4 & !out5 & ro2
    wr(7, 10'h000, 10'h3FF);        // disabled with nonzero value mask
    apply(6'h00, 4'h0, "R2 no hit");
    apply(6'h01, 4'h1, "R3 true form");
    apply(6'h00, 4'h2, "R3 inverted form");
    apply(6'h02, 4'h2, "R3 inverted form clear");
    apply(6'h0C, 4'h0, "R7 two-output row");
    apply(6'h18, 4'h4, "R8 four-bit row");
    apply(6'h1C, 4'h4, "R8 two multi rows");
    apply(6'h3F, 4'hF, "R5 all ones");
    apply(6'h31, 4'h9, "R4 dont-care toggled");
    apply(6'h0D, 4'h3, "R6 single and multi");
    idle();
    apply_wr(6'h20, 4'h8, 4, 10'h220, 10'h220);
    apply(6'h20, 4'h8, "R2 new row used");
    wr(2, 10'h000, 10'h00C);
    apply(6'h0C, 4'h0, "R5 row cleared");

    for (int n = 0; n < 120; n++) begin
      if (n % 8 == 0)
        wr(int'($urandom % NR), VW'($urandom & $urandom & $urandom), VW'($urandom));
      if (n % 17 == 5)
        apply_wr(NO'($urandom), NRO'($urandom), int'($urandom % NR),
                 VW'($urandom & $urandom), VW'($urandom));
      else
        apply(NO'($urandom), NRO'($urandom), "R3 random");
      if (n % 11 == 3) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    chk("R9", "queue drained", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule